// File: doc/BRIEF.md
# Time-Aware Traffic-Class Egress Scheduler

This block merges four prioritised frame streams onto a single output link. The four streams are sync, control, data stream and bulk. Each class arrives as a word stream with a valid/ready handshake. The first word of every frame carries the frame's declared length in words, and the final word is flagged. A free-running slot timer steps through a cyclic list of gate entries. Each entry names the classes whose gates are open and how many clock cycles the slot lasts.

When the link is idle, the scheduler starts a new frame from the highest-priority class that meets three conditions: its gate is open, it has a frame waiting, and that frame fits in what is left of the current slot. Once a frame has started, it keeps the link until its last word, so a gate that closes only blocks the next start. A frame whose declared length exceeds a configured maximum is drained from its queue without reaching the link, and it is counted as a drop.

Each class also has three monitors: the peak queue depth reported by its queue, the number of list cycles in which it waited with its gate shut throughout, and its drop count.

Top module: `tas_egress_sched`

## Requirements
- R1: Class codes are sync=0, control=1, data stream=2, bulk=3. When the link is free, a start goes to the lowest-numbered eligible class. A class is eligible when its gate is open, its valid is high, it is not being drained, its declared length is at most MAX_FRAME_LEN, and the length fits under R3.
- R2: The gate list has GCL_DEPTH entries. Entry i holds a class mask at bits [i*4+3:i*4] of the mask input, where bit c opens class c. It also holds a duration in cycles at bits [i*SLOT_W+SLOT_W-1:i*SLOT_W] of the duration input, and a duration of 0 counts as 1. The list starts at entry 0 after reset, advances after each slot and wraps to entry 0. `gate_state_o` shows the mask of the current entry.
- R3: A frame may start only when its declared length is at most the number of cycles left in the current slot, counting the current cycle. Otherwise the class waits.
- R4: Once a frame's first word is accepted, ready stays with that class alone on the link until its last word is accepted, whatever the gates do. Frames of different classes never interleave.
- R5: A word accepted for the link appears on the output one cycle later, with its class code and last flag. In a cycle with no accepted word, `out_valid_o` is low.
- R6: A frame whose declared length exceeds MAX_FRAME_LEN is consumed with ready held high until its last word, never appears on the output, and adds one to that class's drop counter.
- R7: At the last cycle of each pass through the list, a class's congestion counter adds one if that class had valid high in some cycle of the pass while its gate stayed closed in every slot of the pass.
- R8: Each class's peak-depth output holds the largest depth value presented on its depth input since reset.
- R9: During and straight after reset, the output is idle, the list is at entry 0 and all counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gcl_mask_i | input | GCL_DEPTH*4 | Per-entry class gate masks |
| gcl_dur_i | input | GCL_DEPTH*SLOT_W | Per-entry slot durations in cycles |
| cls_valid_i | input | 4 | Per-class word valid |
| cls_last_i | input | 4 | Per-class last word of frame |
| cls_data_i | input | 4*DATA_W | Per-class data words |
| cls_len_i | input | 4*LEN_W | Per-class declared frame length, meaningful on the first word |
| cls_depth_i | input | 4*DEPTH_W | Per-class queue depth from the queue |
| cls_ready_o | output | 4 | Per-class word accepted |
| out_valid_o | output | 1 | Output word valid |
| out_last_o | output | 1 | Output word ends a frame |
| out_cls_o | output | 2 | Class code of output word |
| out_data_o | output | DATA_W | Output word |
| gate_state_o | output | 4 | Gate mask of the current slot |
| peak_depth_o | output | 4*DEPTH_W | Per-class peak depth |
| congest_cnt_o | output | 4*CNT_W | Per-class congestion events |
| drop_cnt_o | output | 4*CNT_W | Per-class dropped frames |

## Verification
The bench targets the guard band where a frame's length equals the remaining slot cycles or is one cycle larger. A design with an off-by-one here would either let a frame spill into the next slot or waste a slot that it could have used.

It saturates the data class while sync and control arrive sparsely in narrow windows. A wrong priority or gate decode then shows up as a ready pulse to the wrong class. Zero-duration entries and a gate closing mid-frame are also covered. A design that cut frames or switched class mid-frame would interleave words on the output.

Oversize frames and classes whose gates never open test the drain and congestion paths. A mishandled drain leaves the queue stuck or leaks words onto the link, and miscounting at the list wrap shows up in the counters.

// File: rtl/tas_pkg.sv
package tas_pkg;
  localparam int NCLS  = 4;
  localparam int CLS_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_SYNC   = 2'd0,
    CLS_CTRL   = 2'd1,
    CLS_STREAM = 2'd2,
    CLS_BULK   = 2'd3
  } tclass_e;
endpackage

// File: rtl/tas_gate_timer.sv
// Slot timer walking the cyclic gate list.
module tas_gate_timer #(
  parameter int GCL_DEPTH = 8,
  parameter int SLOT_W    = 16,
  parameter int NCLS      = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [GCL_DEPTH*NCLS-1:0]   gcl_mask_i,
  input  logic [GCL_DEPTH*SLOT_W-1:0] gcl_dur_i,
  output logic [NCLS-1:0]             gate_mask_o,
  output logic [SLOT_W-1:0]           remain_o,
  output logic                        list_end_o
);
  localparam int IDX_W = (GCL_DEPTH > 1) ? $clog2(GCL_DEPTH) : 1;

  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [SLOT_W-1:0] el_q, el_d;
  logic [SLOT_W-1:0] dur_raw, dur_eff;
  logic              slot_end, last_entry;

  always_comb begin
    dur_raw     = gcl_dur_i[idx_q*SLOT_W +: SLOT_W];
    dur_eff     = (dur_raw == '0) ? SLOT_W'(1) : dur_raw;
    gate_mask_o = gcl_mask_i[idx_q*NCLS +: NCLS];
    slot_end    = (el_q >= dur_eff - SLOT_W'(1));
    last_entry  = (idx_q == IDX_W'(GCL_DEPTH-1));
    remain_o    = dur_eff - el_q;
    list_end_o  = slot_end && last_entry;
    el_d        = slot_end ? '0 : el_q + SLOT_W'(1);
    idx_d       = idx_q;
    if (slot_end) idx_d = last_entry ? '0 : idx_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      el_q  <= '0;
    end else begin
      idx_q <= idx_d;
      el_q  <= el_d;
    end
  end
endmodule

// File: rtl/tas_link_arbiter.sv
// Frame-boundary strict-priority arbiter with guard band and oversize drain.
module tas_link_arbiter #(
  parameter int NCLS          = 4,
  parameter int CLS_W         = 2,
  parameter int LEN_W         = 8,
  parameter int SLOT_W        = 16,
  parameter int MAX_FRAME_LEN = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCLS-1:0]       valid_i,
  input  logic [NCLS-1:0]       last_i,
  input  logic [NCLS*LEN_W-1:0] len_i,
  input  logic [NCLS-1:0]       gate_i,
  input  logic [SLOT_W-1:0]     remain_i,
  output logic [NCLS-1:0]       ready_o,
  output logic                  acc_o,
  output logic [CLS_W-1:0]      acc_cls_o,
  output logic                  acc_last_o,
  output logic                  start_o,
  output logic                  busy_o,
  output logic [CLS_W-1:0]      cur_o,
  output logic [NCLS-1:0]       drop_evt_o
);
  logic             busy_q, busy_d;
  logic [CLS_W-1:0] cur_q, cur_d;
  logic [NCLS-1:0]  drop_mid_q, drop_mid_d;
  logic [NCLS-1:0]  oversize, fits, own, drain, elig, grant;
  logic [CLS_W-1:0] sel;
  logic             start;

  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      oversize[c] = 32'(len_i[c*LEN_W +: LEN_W]) > MAX_FRAME_LEN;
      fits[c]     = 32'(len_i[c*LEN_W +: LEN_W]) <= 32'(remain_i);
      own[c]      = busy_q && (cur_q == CLS_W'(c));
      drain[c]    = valid_i[c] && !drop_mid_q[c] && !own[c] && oversize[c];
      elig[c]     = gate_i[c] && valid_i[c] && !drop_mid_q[c] && !oversize[c] && fits[c];
    end
    sel = '0;
    for (int c = NCLS-1; c >= 0; c--) begin
      if (elig[c]) sel = CLS_W'(c);
    end
    start = !busy_q && (|elig);
    grant = '0;
    if (busy_q)     grant[cur_q] = 1'b1;
    else if (start) grant[sel]   = 1'b1;
    ready_o    = grant | drop_mid_q | drain;
    acc_cls_o  = busy_q ? cur_q : sel;
    acc_o      = (busy_q || start) && valid_i[acc_cls_o];
    acc_last_o = last_i[acc_cls_o];
    busy_d = busy_q;
    cur_d  = cur_q;
    if (acc_o) begin
      busy_d = !acc_last_o;
      cur_d  = acc_cls_o;
    end
    for (int c = 0; c < NCLS; c++) begin
      drop_mid_d[c] = drop_mid_q[c] ? !(valid_i[c] && last_i[c]) : (drain[c] && !last_i[c]);
    end
    drop_evt_o = drain;
    start_o    = start;
    busy_o     = busy_q;
    cur_o      = cur_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      cur_q      <= '0;
      drop_mid_q <= '0;
    end else begin
      busy_q     <= busy_d;
      drop_mid_q <= drop_mid_d;
      if (acc_o) cur_q <= cur_d;
    end
  end
endmodule

// File: rtl/tas_class_stats.sv
// Per-class peak depth, congestion and drop monitors.
module tas_class_stats #(
  parameter int DEPTH_W = 8,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic               pending_i,
  input  logic               gate_i,
  input  logic               list_end_i,
  input  logic               drop_i,
  output logic [DEPTH_W-1:0] peak_o,
  output logic [CNT_W-1:0]   cong_o,
  output logic [CNT_W-1:0]   drop_o
);
  logic pend_q, pend_d, seen_q, seen_d;
  logic cong_evt, peak_en, cong_en, drop_en;

  always_comb begin
    cong_evt = list_end_i && (pend_q || pending_i) && !(seen_q || gate_i);
    pend_d   = list_end_i ? 1'b0 : (pend_q || pending_i);
    seen_d   = list_end_i ? 1'b0 : (seen_q || gate_i);
    peak_en  = depth_i > peak_o;
    cong_en  = cong_evt && (cong_o != '1);
    drop_en  = drop_i && (drop_o != '1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      seen_q <= 1'b0;
      peak_o <= '0;
      cong_o <= '0;
      drop_o <= '0;
    end else begin
      pend_q <= pend_d;
      seen_q <= seen_d;
      if (peak_en) peak_o <= depth_i;
      if (cong_en) cong_o <= cong_o + CNT_W'(1);
      if (drop_en) drop_o <= drop_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/tas_egress_sched.sv
module tas_egress_sched
  import tas_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int LEN_W         = 8,
  parameter int SLOT_W        = 16,
  parameter int GCL_DEPTH     = 8,
  parameter int MAX_FRAME_LEN = 16,
  parameter int DEPTH_W       = 8,
  parameter int CNT_W         = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [GCL_DEPTH*NCLS-1:0]     gcl_mask_i,
  input  logic [GCL_DEPTH*SLOT_W-1:0]   gcl_dur_i,
  input  logic [NCLS-1:0]               cls_valid_i,
  input  logic [NCLS-1:0]               cls_last_i,
  input  logic [NCLS*DATA_W-1:0]        cls_data_i,
  input  logic [NCLS*LEN_W-1:0]         cls_len_i,
  input  logic [NCLS*DEPTH_W-1:0]       cls_depth_i,
  output logic [NCLS-1:0]               cls_ready_o,
  output logic                          out_valid_o,
  output logic                          out_last_o,
  output logic [CLS_W-1:0]              out_cls_o,
  output logic [DATA_W-1:0]             out_data_o,
  output logic [NCLS-1:0]               gate_state_o,
  output logic [NCLS*DEPTH_W-1:0]       peak_depth_o,
  output logic [NCLS*CNT_W-1:0]         congest_cnt_o,
  output logic [NCLS*CNT_W-1:0]         drop_cnt_o
);
  logic [SLOT_W-1:0] remain;
  logic              list_end;
  logic              link_acc, acc_last, link_start, busy;
  logic [CLS_W-1:0]  link_sel, cur;
  logic [NCLS-1:0]   drop_evt;
  logic [DATA_W-1:0] acc_data;

  tas_gate_timer #(
    .GCL_DEPTH(GCL_DEPTH), .SLOT_W(SLOT_W), .NCLS(NCLS)
  ) u_timer (
    .clk(clk), .rst_n(rst_n),
    .gcl_mask_i(gcl_mask_i), .gcl_dur_i(gcl_dur_i),
    .gate_mask_o(gate_state_o), .remain_o(remain), .list_end_o(list_end)
  );

  tas_link_arbiter #(
    .NCLS(NCLS), .CLS_W(CLS_W), .LEN_W(LEN_W), .SLOT_W(SLOT_W),
    .MAX_FRAME_LEN(MAX_FRAME_LEN)
  ) u_arb (
    .clk(clk), .rst_n(rst_n),
    .valid_i(cls_valid_i), .last_i(cls_last_i), .len_i(cls_len_i),
    .gate_i(gate_state_o), .remain_i(remain),
    .ready_o(cls_ready_o), .acc_o(link_acc), .acc_cls_o(link_sel),
    .acc_last_o(acc_last), .start_o(link_start), .busy_o(busy),
    .cur_o(cur), .drop_evt_o(drop_evt)
  );

  for (genvar c = 0; c < NCLS; c++) begin : g_stats
    tas_class_stats #(.DEPTH_W(DEPTH_W), .CNT_W(CNT_W)) u_stats (
      .clk(clk), .rst_n(rst_n),
      .depth_i(cls_depth_i[c*DEPTH_W +: DEPTH_W]),
      .pending_i(cls_valid_i[c]),
      .gate_i(gate_state_o[c]),
      .list_end_i(list_end),
      .drop_i(drop_evt[c]),
      .peak_o(peak_depth_o[c*DEPTH_W +: DEPTH_W]),
      .cong_o(congest_cnt_o[c*CNT_W +: CNT_W]),
      .drop_o(drop_cnt_o[c*CNT_W +: CNT_W])
    );
  end

  always_comb acc_data = cls_data_i[link_sel*DATA_W +: DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      out_last_o  <= 1'b0;
      out_cls_o   <= '0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= link_acc;
      if (link_acc) begin
        out_last_o <= acc_last;
        out_cls_o  <= link_sel;
        out_data_o <= acc_data;
      end
    end
  end
endmodule

// File: rtl/tas_egress_sched_chk.sv
module tas_egress_sched_chk #(
  parameter int NCLS          = 4,
  parameter int CLS_W         = 2,
  parameter int LEN_W         = 8,
  parameter int SLOT_W        = 16,
  parameter int MAX_FRAME_LEN = 16,
  parameter int CNT_W         = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NCLS-1:0]       cls_valid_i,
  input logic [NCLS*LEN_W-1:0] cls_len_i,
  input logic [NCLS-1:0]       cls_ready_o,
  input logic [NCLS-1:0]       gate_state_o,
  input logic [SLOT_W-1:0]     remain,
  input logic                  link_start,
  input logic [CLS_W-1:0]      link_sel,
  input logic                  link_acc,
  input logic                  acc_last,
  input logic                  busy,
  input logic [CLS_W-1:0]      cur,
  input logic                  out_valid_o,
  input logic                  out_last_o,
  input logic [CLS_W-1:0]      out_cls_o,
  input logic [NCLS*CNT_W-1:0] drop_cnt_o
);
  logic hi_block;
  logic sel_fits;

  always_comb begin
    hi_block = 1'b0;
    for (int c = 0; c < NCLS; c++) begin
      if (c < int'(link_sel) && gate_state_o[c] && cls_valid_i[c] && !cls_ready_o[c] &&
          32'(cls_len_i[c*LEN_W +: LEN_W]) <= MAX_FRAME_LEN &&
          32'(cls_len_i[c*LEN_W +: LEN_W]) <= 32'(remain))
        hi_block = 1'b1;
    end
    sel_fits = 32'(cls_len_i[link_sel*LEN_W +: LEN_W]) <= 32'(remain);
  end

  p_priority_r1: assert property (@(posedge clk) disable iff (!rst_n)
    link_start |-> !hi_block);

  p_start_gate_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    link_start |-> gate_state_o[link_sel]);

  p_guard_fit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    link_start |-> sel_fits);

  p_no_cut_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(link_acc && acc_last)) |=> (busy && $stable(cur)));

  p_out_one_class_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_last_o) |=> (!out_valid_o || out_cls_o == $past(out_cls_o)));

  for (genvar c = 0; c < NCLS; c++) begin : g_mono
    p_drop_mono_r6: assert property (@(posedge clk) disable iff (!rst_n)
      drop_cnt_o[c*CNT_W +: CNT_W] >= $past(drop_cnt_o[c*CNT_W +: CNT_W]));
  end
endmodule

bind tas_egress_sched tas_egress_sched_chk #(
  .NCLS(NCLS), .CLS_W(CLS_W), .LEN_W(LEN_W), .SLOT_W(SLOT_W),
  .MAX_FRAME_LEN(MAX_FRAME_LEN), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cls_valid_i(cls_valid_i), .cls_len_i(cls_len_i),
  .cls_ready_o(cls_ready_o), .gate_state_o(gate_state_o), .remain(remain),
  .link_start(link_start), .link_sel(link_sel), .link_acc(link_acc),
  .acc_last(acc_last), .busy(busy), .cur(cur), .out_valid_o(out_valid_o),
  .out_last_o(out_last_o), .out_cls_o(out_cls_o), .drop_cnt_o(drop_cnt_o)
);

// File: tb/tb_tas_egress_sched.sv
module tb_tas_egress_sched;
  localparam int NCLS = 4, DATA_W = 32, LEN_W = 8, SLOT_W = 16, GCL_DEPTH = 8;
  localparam int MAXLEN = 16, DEPTH_W = 8, CNT_W = 16;

  logic clk, rst_n;
  logic [GCL_DEPTH*NCLS-1:0]   gcl_mask;
  logic [GCL_DEPTH*SLOT_W-1:0] gcl_dur;
  logic [NCLS-1:0]             c_valid, c_last, c_ready;
  logic [NCLS*DATA_W-1:0]      c_data;
  logic [NCLS*LEN_W-1:0]       c_len;
  logic [NCLS*DEPTH_W-1:0]     c_depth;
  logic                        o_valid, o_last;
  logic [1:0]                  o_cls;
  logic [DATA_W-1:0]           o_data;
  logic [NCLS-1:0]             g_state;
  logic [NCLS*DEPTH_W-1:0]     peak;
  logic [NCLS*CNT_W-1:0]       cong, drops;

  tas_egress_sched dut (
    .clk(clk), .rst_n(rst_n), .gcl_mask_i(gcl_mask), .gcl_dur_i(gcl_dur),
    .cls_valid_i(c_valid), .cls_last_i(c_last), .cls_data_i(c_data),
    .cls_len_i(c_len), .cls_depth_i(c_depth), .cls_ready_o(c_ready),
    .out_valid_o(o_valid), .out_last_o(o_last), .out_cls_o(o_cls),
    .out_data_o(o_data), .gate_state_o(g_state), .peak_depth_o(peak),
    .congest_cnt_o(cong), .drop_cnt_o(drops)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  // gate list and traffic profile
  int gm[GCL_DEPTH], gd[GCL_DEPTH];
  int ld[NCLS], lmax[NCLS], ovr[NCLS];
  // sources
  bit s_act[NCLS];
  int s_len[NCLS], s_pos[NCLS], s_seq[NCLS];
  // reference model
  int m_idx, m_el, m_cur;
  bit m_busy;
  bit m_dmid[NCLS], m_pend[NCLS], m_seen[NCLS], m_drain[NCLS], er[NCLS], m_lnk[NCLS];
  int m_cong[NCLS], m_drop[NCLS], m_peak[NCLS];
  bit e_ov, e_ol;
  int e_oc;
  logic [31:0] e_od;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int dur_e(input int i);
    return (gd[i] == 0) ? 1 : gd[i];
  endfunction

  function automatic logic [31:0] word_of(input int c);
    return (32'(c) << 24) | ((32'(s_seq[c]) & 32'hffff) << 8) | (32'(s_pos[c]) & 32'hff);
  endfunction

  task automatic apply_gcl();
    for (int i = 0; i < GCL_DEPTH; i++) begin
      gcl_mask[i*NCLS +: NCLS]   = NCLS'(gm[i]);
      gcl_dur[i*SLOT_W +: SLOT_W] = SLOT_W'(gd[i]);
    end
  endtask

  task automatic drive();
    for (int c = 0; c < NCLS; c++) begin
      c_valid[c] = s_act[c];
      c_last[c]  = s_act[c] && (s_pos[c] == s_len[c] - 1);
      c_len[c*LEN_W +: LEN_W]     = LEN_W'(s_len[c]);
      c_data[c*DATA_W +: DATA_W]  = word_of(c);
      c_depth[c*DEPTH_W +: DEPTH_W] = DEPTH_W'($urandom % 256);
    end
  endtask

  // expected ready vector from the requirements (R1, R3, R4, R6)
  task automatic model_ready();
    int rem;
    int sel;
    rem = dur_e(m_idx) - m_el;
    sel = -1;
    for (int c = 0; c < NCLS; c++) begin
      m_lnk[c] = 0;
      m_drain[c] = s_act[c] && !m_dmid[c] && !(m_busy && m_cur == c) && s_len[c] > MAXLEN;
    end
    if (m_busy) m_lnk[m_cur] = 1;
    else begin
      for (int c = NCLS-1; c >= 0; c--)
        if (((gm[m_idx] >> c) & 1) == 1 && s_act[c] && !m_dmid[c] &&
            s_len[c] <= MAXLEN && s_len[c] <= rem) sel = c;
      if (sel >= 0) m_lnk[sel] = 1;
    end
    for (int c = 0; c < NCLS; c++) er[c] = m_lnk[c] || m_dmid[c] || m_drain[c];
  endtask

  task automatic model_advance();
    bit ending;
    e_ov = 0;
    for (int c = 0; c < NCLS; c++) begin
      if (m_lnk[c] && s_act[c]) begin
        e_ov = 1; e_od = word_of(c); e_oc = c;
        e_ol = (s_pos[c] == s_len[c] - 1);
        m_busy = !e_ol; m_cur = c;
      end
    end
    for (int c = 0; c < NCLS; c++) begin
      if (m_dmid[c]) begin
        if (s_act[c] && s_pos[c] == s_len[c] - 1) m_dmid[c] = 0;
      end else if (m_drain[c]) begin
        m_drop[c]++;
        if (s_pos[c] != s_len[c] - 1) m_dmid[c] = 1;
      end
    end
    ending = (m_el >= dur_e(m_idx) - 1) && (m_idx == GCL_DEPTH - 1);
    for (int c = 0; c < NCLS; c++) begin
      bit g;
      g = ((gm[m_idx] >> c) & 1) == 1;
      if (ending) begin
        if ((m_pend[c] || s_act[c]) && !(m_seen[c] || g)) m_cong[c]++;
        m_pend[c] = 0; m_seen[c] = 0;
      end else begin
        m_pend[c] = m_pend[c] || s_act[c];
        m_seen[c] = m_seen[c] || g;
      end
      if (int'(c_depth[c*DEPTH_W +: DEPTH_W]) > m_peak[c]) m_peak[c] = int'(c_depth[c*DEPTH_W +: DEPTH_W]);
    end
    if (m_el >= dur_e(m_idx) - 1) begin
      m_el = 0;
      m_idx = (m_idx == GCL_DEPTH - 1) ? 0 : m_idx + 1;
    end else m_el++;
    // source side
    for (int c = 0; c < NCLS; c++) begin
      if (s_act[c] && er[c]) begin
        if (s_pos[c] == s_len[c] - 1) begin s_act[c] = 0; s_seq[c]++; end
        else s_pos[c]++;
      end
      if (!s_act[c] && int'($urandom % 100) < ld[c]) begin
        s_act[c] = 1; s_pos[c] = 0;
        if (int'($urandom % 100) < ovr[c]) s_len[c] = MAXLEN + 1 + int'($urandom % 4);
        else s_len[c] = 1 + int'($urandom % lmax[c]);
      end
    end
  endtask

  task automatic step();
    logic [NCLS-1:0] exp_r;
    // R5: registered output, R2: current gate mask
    check(o_valid == e_ov, "R5", "out_valid", o_valid, e_ov);
    if (e_ov) begin
      check(o_data == e_od && o_cls == 2'(e_oc) && o_last == e_ol, "R5", "out word/cls/last",
            {o_data, o_cls, o_last}, {e_od, 2'(e_oc), e_ol});
    end
    check(g_state == NCLS'(gm[m_idx]), "R2", "gate_state", g_state, gm[m_idx]);
    drive();
    #1;
    model_ready();
    for (int c = 0; c < NCLS; c++) exp_r[c] = er[c];
    check(c_ready == exp_r, "R1/R3/R4/R6", "ready vector", c_ready, exp_r);
    model_advance();
    @(negedge clk);
  endtask

  task automatic check_counters(input string tag);
    for (int c = 0; c < NCLS; c++) begin
      check(int'(drops[c*CNT_W +: CNT_W]) == m_drop[c], "R6", {tag, " drop count"},
            drops[c*CNT_W +: CNT_W], m_drop[c]);
      check(int'(cong[c*CNT_W +: CNT_W]) == m_cong[c], "R7", {tag, " congestion count"},
            cong[c*CNT_W +: CNT_W], m_cong[c]);
      check(int'(peak[c*DEPTH_W +: DEPTH_W]) == m_peak[c], "R8", {tag, " peak depth"},
            peak[c*DEPTH_W +: DEPTH_W], m_peak[c]);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    c_valid = '0; c_last = '0; c_data = '0; c_len = '0; c_depth = '0;
    m_idx = 0; m_el = 0; m_busy = 0; m_cur = 0;
    e_ov = 0; e_ol = 0; e_oc = 0; e_od = '0;
    for (int c = 0; c < NCLS; c++) begin
      m_dmid[c] = 0; m_pend[c] = 0; m_seen[c] = 0;
      m_cong[c] = 0; m_drop[c] = 0; m_peak[c] = 0;
      s_act[c] = 0; s_pos[c] = 0; s_len[c] = 1;
    end
    apply_gcl();
    repeat (3) @(negedge clk);
    // R9: reset state
    check(o_valid == 1'b0, "R9", "out_valid in reset", o_valid, 0);
    check(g_state == NCLS'(gm[0]), "R9", "list at entry 0", g_state, gm[0]);
    check(cong == '0 && drops == '0 && peak == '0, "R9", "counters zero", |{cong, drops, peak}, 0);
    rst_n = 1'b1;
  endtask

  task automatic run(input int n, input string tag);
    repeat (n) step();
    check_counters(tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R5 watchdog: actual %0d cycles expected fewer", 190000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    @(negedge clk);

    // random gate lists and mixed traffic (R1..R8)
    for (int i = 0; i < GCL_DEPTH; i++) begin gm[i] = int'($urandom % 16); gd[i] = int'($urandom % 13); end
    for (int c = 0; c < NCLS; c++) begin ld[c] = 30 + int'($urandom % 40); lmax[c] = 1 + int'($urandom % 10); ovr[c] = 5; end
    do_reset();
    run(3000, "random");

    // saturated data class, narrow sync/control windows, zero-length slot (R1, R2, R3, R4)
    gm = '{1, 2, 12, 4, 15, 0, 8, 6};
    gd = '{4, 4, 20, 0, 10, 3, 5, 7};
    ld = '{20, 30, 100, 60}; lmax = '{2, 3, 16, 8}; ovr = '{0, 0, 0, 2};
    do_reset();
    run(3000, "saturated");

    // gates that never open for control/bulk, heavy oversize (R6, R7)
    gm = '{1, 0, 4, 5, 1, 0, 4, 0};
    gd = '{3, 2, 6, 4, 1, 2, 5, 3};
    ld = '{50, 80, 60, 100}; lmax = '{3, 4, 6, 5}; ovr = '{30, 30, 30, 30};
    do_reset();
    run(2000, "congestion");

    // guard band edge: only a 5-cycle data window, lengths 1..6 (R3)
    gm = '{4, 0, 0, 0, 0, 0, 0, 0};
    gd = '{5, 1, 1, 1, 1, 1, 1, 1};
    ld = '{0, 0, 100, 0}; lmax = '{1, 1, 6, 1}; ovr = '{0, 0, 0, 0};
    do_reset();
    run(1500, "guard");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule